// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a direct-mapped data cache that sits between a 32-bit byte-addressed load/store port and a simple next-level memory. It holds 64 lines of 16 bytes. Each line has a valid bit and a 22-bit tag. A load that hits returns its word combinationally in the cycle it is presented. A load that misses holds the CPU in a stall while the cache brings in the whole line as four word reads. The access then completes as a hit.

Stores follow a write-through policy with no allocation on a miss. Every accepted store goes into a four-entry posted write buffer, which drains to memory in arrival order. A store that hits also updates the cached word. A store that misses leaves the cache untouched. The CPU stalls on a store only when the buffer is full. Before any line fill starts, the buffer is emptied, so a fill can never return data older than a posted store.

CPU handshake: an access is presented with `cpu_req` high. It completes on the rising edge where `cpu_req` is high and `cpu_stall` is low. While the access is stalled, the CPU must hold `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady.

Memory write channel (valid/ready): the cache raises `mem_wr_valid` whenever the buffer holds an entry. An entry transfers on an edge where both `mem_wr_valid` and `mem_wr_ready` are high. While ready is low, the valid, address and data outputs stay unchanged. Memory read channel: `mem_rd_req` is held high with a word address until one cycle of `mem_rd_ack` returns the data.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid. The first load to any address misses and raises `cpu_stall`. With no request present, `cpu_stall`, `mem_rd_req` and `mem_wr_valid` are all low.
- R2: The address splits into a byte offset in bits [3:0], a line index in bits [9:4] and a tag in bits [31:10]. Bits [3:2] select the word within the line. Byte address 1200 maps to index 11 and shares its line with 1204. Address 1200+1024 maps to the same index with a different tag, so it evicts 1200.
- R3: A load hits when the indexed line is valid and its stored tag equals the address tag. A hit completes with `cpu_stall` low in the cycle it is presented, and `cpu_rdata` holds the word.
- R4: A load miss keeps `cpu_stall` high. The cache then reads the four words of the line at offsets 0, 4, 8 and 12, in that order, each held on `mem_rd_addr` until acknowledged. It then marks the line valid with the new tag, and the held load completes in the following cycle.
- R5: A store that hits updates the cached word, so later loads return the new value. The store is also written to memory.
- R6: A store that misses does not fetch or allocate a line. A later load of that address misses, and the data it fetches contains the stored value.
- R7: An accepted store does not stall while the write buffer holds fewer than 4 entries, and it raises `mem_wr_valid` on the next cycle. A store presented while 4 entries are pending stalls until an entry drains.
- R8: Buffered stores reach memory one per handshake, in the order they were accepted, with the exact address and data. The outputs stay stable while `mem_wr_ready` is low.
- R9: `mem_rd_req` is never high while any store is still pending in the write buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the load completes |
| cpu_stall | output | 1 | Access not completing this cycle |
| mem_rd_req | output | 1 | Fill word read request |
| mem_rd_addr | output | 32 | Fill word address |
| mem_rd_ack | input | 1 | Fill word returned (one cycle) |
| mem_rd_data | input | 32 | Fill word data |
| mem_wr_valid | output | 1 | Buffered store available |
| mem_wr_ready | input | 1 | Memory accepts the store |
| mem_wr_addr | output | 32 | Store address to memory |
| mem_wr_data | output | 32 | Store data to memory |

## Verification
The properties assume a CPU that keeps its request, direction, address and data unchanged for as long as `cpu_stall` is high. They also assume a memory that pulses `mem_rd_ack` for one cycle, and only while `mem_rd_req` is high. The stimulus meets the CPU side by driving each access once and then only waiting for the stall to drop. The bench's memory model meets the read side by raising the acknowledge after a random delay and clearing it on the following cycle, and it toggles `mem_wr_ready` at random. Randomized addresses stay inside a 4 KB window, so that several tags compete for each index.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  // Controller phases: serve hits/stores, empty the store buffer, fetch a line.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } dc_state_e;
endpackage

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int LINES  = 64,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 6,
  parameter int WOFF_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WOFF_W-1:0] lk_woff,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wd_en,
  input  logic [WOFF_W-1:0] wd_woff,
  input  logic [DATA_W-1:0] wd_data,
  input  logic              tag_en
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] lane_rd [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (tag_en) valid_q[lk_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (tag_en) tag_q[lk_idx] <= lk_tag;
  end

  // One storage lane per word position within a line.
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [DATA_W-1:0] bank_q [LINES];
    always_ff @(posedge clk) begin
      if (wd_en && (wd_woff == WOFF_W'(w))) bank_q[lk_idx] <= wd_data;
    end
    assign lane_rd[w] = bank_q[lk_idx];
  end

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = lane_rd[lk_woff];
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);
  assign out_valid = !empty;
  assign out_addr  = addr_q[rd_ptr_q];
  assign out_data  = data_q[rd_ptr_q];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WOFF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              lk_hit,
  input  logic              wb_full,
  input  logic              wb_empty,
  input  logic              mem_rd_ack,
  output logic              cpu_stall,
  output logic              wb_push,
  output logic              wd_en,
  output logic              wd_from_mem,
  output logic              tag_en,
  output logic              mem_rd_req,
  output logic [WOFF_W-1:0] fill_woff
);
  localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(WORDS - 1);

  dc_state_e         state_q, state_d;
  logic [WOFF_W-1:0] cnt_q;

  always_comb begin
    state_d     = state_q;
    cpu_stall   = 1'b0;
    wb_push     = 1'b0;
    wd_en       = 1'b0;
    wd_from_mem = 1'b0;
    tag_en      = 1'b0;
    mem_rd_req  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we) begin
            cpu_stall = wb_full;
            wb_push   = !wb_full;
            wd_en     = !wb_full && lk_hit;
          end else if (!lk_hit) begin
            cpu_stall = 1'b1;
            state_d   = wb_empty ? ST_FILL : ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        cpu_stall = 1'b1;
        if (wb_empty) state_d = ST_FILL;
      end
      ST_FILL: begin
        cpu_stall   = 1'b1;
        mem_rd_req  = 1'b1;
        wd_from_mem = 1'b1;
        if (mem_rd_ack) begin
          wd_en = 1'b1;
          if (cnt_q == LAST_WORD) begin
            tag_en  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FILL && mem_rd_ack) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fill_woff = cnt_q;
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic [WOFF_W-1:0] a_woff, fill_woff, wd_woff;
  logic [DATA_W-1:0] wd_data;
  logic lk_hit, wd_en, wd_from_mem, tag_en, wb_push, wb_full, wb_empty;

  assign a_idx  = cpu_addr[OFF_W +: IDX_W];
  assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_woff = cpu_addr[BYTE_W +: WOFF_W];

  assign wd_woff     = wd_from_mem ? fill_woff : a_woff;
  assign wd_data     = wd_from_mem ? mem_rd_data : cpu_wdata;
  assign mem_rd_addr = {cpu_addr[ADDR_W-1:OFF_W], fill_woff, {BYTE_W{1'b0}}};

  dc_line_store #(
    .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .WOFF_W(WOFF_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(a_idx), .lk_tag(a_tag), .lk_woff(a_woff),
    .lk_hit(lk_hit), .lk_data(cpu_rdata),
    .wd_en(wd_en), .wd_woff(wd_woff), .wd_data(wd_data),
    .tag_en(tag_en)
  );

  dc_wbuf #(.DEPTH(WB_DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .push_addr(cpu_addr), .push_data(cpu_wdata),
    .full(wb_full), .empty(wb_empty),
    .out_valid(mem_wr_valid), .out_ready(mem_wr_ready),
    .out_addr(mem_wr_addr), .out_data(mem_wr_data)
  );

  dc_ctrl #(.WORDS(WORDS), .WOFF_W(WOFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .lk_hit(lk_hit),
    .wb_full(wb_full), .wb_empty(wb_empty), .mem_rd_ack(mem_rd_ack),
    .cpu_stall(cpu_stall), .wb_push(wb_push), .wd_en(wd_en),
    .wd_from_mem(wd_from_mem), .tag_en(tag_en),
    .mem_rd_req(mem_rd_req), .fill_woff(fill_woff)
  );
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              mem_rd_req,
  input logic              mem_rd_ack,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data
);
  // R9: no fill read while stores are still pending
  p_fill_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_valid);

  // R8: write channel holds its payload under back-pressure
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R4: a fill request is held with its address until acknowledged
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R4: fill reads target the line of the stalled load, and the CPU waits
  p_fill_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (cpu_stall && !cpu_we &&
                    mem_rd_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

  // R3: once the fill ends, the held load completes as a hit
  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_req) |-> (cpu_req && !cpu_we && !cpu_stall));

  // R7: an accepted store shows up on the write channel next cycle
  p_store_post_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall) |=> mem_wr_valid);
endmodule

bind wt_dcache wt_dcache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req),
  .mem_rd_ack(mem_rd_ack), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;

  wt_dcache u_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_hit = 0, n_miss = 0;
  bit done = 1'b0;
  bit hold_ready = 1'b0;
  int rd_wait = 0, fill_cnt = 0;
  logic [31:0] back_mem [MEM_WORDS];
  logic [31:0] ref_mem  [MEM_WORDS];
  logic [63:0] exp_wq [$];
  bit          m_valid [64];
  logic [21:0] m_tag   [64];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("hits %0d misses %0d", n_hit, n_miss);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Next-level memory: fill responder (R4 order check) and ready generator.
  always @(negedge clk) begin
    mem_wr_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
    if (mem_rd_ack) mem_rd_ack = 1'b0;
    else if (mem_rd_req) begin
      if (rd_wait > 0) rd_wait--;
      else begin
        chk("R4 fill word order", mem_rd_addr,
            {cpu_addr[31:4], 2'(fill_cnt), 2'b00});
        mem_rd_data = back_mem[mem_rd_addr[11:2]];
        mem_rd_ack  = 1'b1;
        fill_cnt    = (fill_cnt + 1) % 4;
        rd_wait     = $urandom % 3;
      end
    end
  end

  // Write sink: R8 order and payload against the bench's accepted-store queue.
  always @(posedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (exp_wq.size() == 0) chk("R8 unexpected store", 32'd1, 32'd0);
      else begin
        logic [63:0] e;
        e = exp_wq.pop_front();
        chk("R8 store addr", mem_wr_addr, e[63:32]);
        chk("R8 store data", mem_wr_data, e[31:0]);
      end
      back_mem[mem_wr_addr[11:2]] = mem_wr_data;
    end
  end

  task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    st = cpu_stall;
  endtask

  task automatic finish(output logic [31:0] rd);
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    rd = cpu_rdata;
    if (cpu_we) begin
      ref_mem[cpu_addr[11:2]] = cpu_wdata;
      exp_wq.push_back({cpu_addr, cpu_wdata});
    end
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
  endtask

  // Load with hit/miss prediction from the index [9:4] / tag [31:10] split.
  task automatic rd_chk(input logic [31:0] a, input string rq, input int hold);
    logic st;
    logic [31:0] rd;
    bit exp_hit;
    exp_hit = m_valid[a[9:4]] && (m_tag[a[9:4]] == a[31:10]);
    issue(1'b0, a, 32'd0, st);
    chk({rq, " stall on first cycle"}, 32'(st), 32'(!exp_hit));
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        #1;
        chk("R9 fill held while stores pending", 32'(mem_rd_req), 32'd0);
      end
      hold_ready = 1'b0;
    end
    finish(rd);
    chk({rq, " load data"}, rd, ref_mem[a[11:2]]);
    m_valid[a[9:4]] = 1'b1;
    m_tag[a[9:4]]   = a[31:10];
    if (exp_hit) n_hit++; else n_miss++;
  endtask

  task automatic wr_do(input logic [31:0] a, input logic [31:0] d);
    logic st;
    logic [31:0] rd;
    issue(1'b1, a, d, st);
    finish(rd);
  endtask

  task automatic wait_drain();
    hold_ready = 1'b0;
    while (mem_wr_valid || exp_wq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic st;
    logic [31:0] rd;
    void'($urandom(32'd20241121));
    for (int i = 0; i < MEM_WORDS; i++) begin
      back_mem[i] = $urandom;
      ref_mem[i]  = back_mem[i];
    end
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 1'b0;
      m_tag[i]   = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 idle stall", 32'(cpu_stall), 32'd0);
    chk("R1 idle fill req", 32'(mem_rd_req), 32'd0);
    chk("R1 idle write valid", 32'(mem_wr_valid), 32'd0);

    // R1/R2/R3: address 1200 sits at index 11; 1204 shares it; +1024 conflicts.
    rd_chk(32'd1200, "R1 cold miss", 0);
    rd_chk(32'd1200, "R3 hit", 0);
    rd_chk(32'd1204, "R2 same line", 0);
    rd_chk(32'd1200 + 32'd1024, "R2 conflict", 0);
    rd_chk(32'd1200, "R2 evicted", 0);
    rd_chk(32'd1216, "R2 next index", 0);

    // R5: store hit updates the cached word.
    rd_chk(32'h40, "R5 prime", 0);
    wr_do(32'h40, 32'hCAFE_0040);
    rd_chk(32'h40, "R5 hit after store", 0);

    // R6: store miss does not allocate.
    wr_do(32'hA40, 32'h1234_5678);
    rd_chk(32'hA40, "R6 load after store miss", 0);

    // R7: four stores post without stall, fifth stalls.
    wait_drain();
    hold_ready = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      issue(1'b1, 32'h100 + 32'(i * 4), 32'hA000 + 32'(i), st);
      chk("R7 store below full", 32'(st), 32'd0);
      finish(rd);
    end
    issue(1'b1, 32'h110, 32'hA004, st);
    chk("R7 store when full", 32'(st), 32'd1);
    hold_ready = 1'b0;
    finish(rd);

    // R9: a load miss waits for pending stores before filling.
    wait_drain();
    hold_ready = 1'b1;
    @(negedge clk);
    wr_do(32'h500, 32'hBEEF_0500);
    wr_do(32'h504, 32'hBEEF_0504);
    rd_chk(32'h500, "R9 miss behind stores", 5);

    // Random mix of loads and stores in a 4 KB window.
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      if ($urandom % 2) a = {20'd0, 2'($urandom), 4'($urandom % 3), 4'($urandom), 2'b00};
      else              a = {20'd0, 10'($urandom), 2'b00};
      if (($urandom % 10) < 4) wr_do(a, $urandom);
      else                     rd_chk(a, "R3/R4 random load", 0);
    end

    wait_drain();
    repeat (4) @(negedge clk);
    chk("R8 all stores drained", 32'(exp_wq.size()), 32'd0);
    begin
      int diffs = 0;
      for (int i = 0; i < MEM_WORDS; i++) if (back_mem[i] !== ref_mem[i]) diffs++;
      chk("R5 memory image after drain", 32'(diffs), 32'd0);
    end
    chk("R3 hits seen", 32'(n_hit > 0), 32'd1);
    summary();
  end
endmodule